// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block sits on the transmit side of a full-duplex Ethernet MAC and produces MAC control pause frames. It decides when to send an XOFF frame, which carries a programmable nonzero pause time, and when to send an XON frame, which carries a pause time of zero. The receiving station uses these frames to stop or resume its own transmission.

Requests come from three places. The first is a receive FIFO whose fill level reaches a programmable threshold. The second is a pair of software register bits. The third is a pair of external request pins. When a request is pending, the block raises a request toward the transmit arbiter. Once the arbiter grants the interface, the block drives a complete minimum-size frame byte by byte on an 8-bit GMII-style interface. The frame includes the preamble, the start delimiter, padding and the frame check sequence. A held request produces a stream of back-to-back frames, each separated by an enforced inter-frame gap.

Top module: `pause_frame_gen`

## Requirements
- R1: When `fc_enable` is 0, no trigger has any effect: `tx_req` stays 0 and no frame starts. A FIFO threshold crossing that occurs while the block is disabled is discarded and does not produce a frame when the block is later enabled.
- R2: The register bit and the pin of each request type are ORed together. Either one alone, or both together, acts as the XOFF (or XON) request.
- R3: While the XOFF request is held, XOFF frames are sent one after another until the request is cleared. Each XOFF frame carries the value of `pause_quanta` sampled at the start of that frame.
- R4: While only the XON request is held, XON frames are sent one after another until the request is cleared. Each XON frame carries a pause time of 0x0000.
- R5: When the XOFF and XON requests are both set, the block sends XOFF frames.
- R6: A rise of `fifo_level` to a value at or above `fifo_threshold` (unsigned compare) produces exactly one XOFF frame. Another crossing produces a frame only after the level has dropped below the threshold for at least one cycle.
- R7: Each frame is 72 bytes, sent in this order:
  - seven bytes of 0x55, then 0xD5;
  - destination address 01 80 C2 00 00 01;
  - `src_mac`, most significant byte first;
  - type 88 08, then opcode 00 01;
  - the 16-bit pause time, high byte first;
  - zero bytes until the 60-byte body is complete;
  - four FCS bytes.
- R8: The FCS is a reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, result inverted) computed over the 60 body bytes. It is sent least significant byte first.
- R9: `tx_req` is 1 exactly when a request is pending and no frame or gap is in progress. A frame starts only on a clock edge where both `tx_req` and `tx_grant` are 1. The first preamble byte appears on `txd` with `tx_en`=1 in the cycle that follows that edge.
- R10: Once a frame has started, `tx_en` stays 1 for all 72 bytes. This holds even if `tx_grant`, `fc_enable` or the requests are removed during the frame.
- R11: At least 12 cycles with `tx_en`=0 lie between consecutive frames. When the request and the grant are both held, the gap is exactly 13 cycles.
- R12: During and directly after reset, `tx_en`, `tx_req` and `txd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_enable | input | 1 | Full-duplex flow-control enable |
| fifo_level | input | LEVEL_W | Receive FIFO fill level |
| fifo_threshold | input | LEVEL_W | Fill level that triggers an XOFF frame |
| xoff_reg_req | input | 1 | XOFF request from a software register bit |
| xon_reg_req | input | 1 | XON request from a software register bit |
| xoff_pin_req | input | 1 | XOFF request from an external pin |
| xon_pin_req | input | 1 | XON request from an external pin |
| pause_quanta | input | 16 | Pause time carried by XOFF frames |
| src_mac | input | 48 | Station source address |
| tx_grant | input | 1 | Transmit arbiter grants the interface |
| tx_req | output | 1 | Request for the transmit interface |
| tx_en | output | 1 | Transmit byte valid |
| txd | output | 8 | Transmit byte |

## Verification
The main function is driven with a table of request patterns:
- each of the four request inputs on its own;
- register and pin requests mixed;
- XOFF and XON together;
- the same requests with the enable cleared.

Comparing every byte of the frame against an independently built frame separates a wrong frame type, a wrong pause value, a wrong field order and a wrong CRC.

Directed cases cover three more areas:
- a withheld grant, which shows the start latency;
- a held request, which shows repetition and the exact gap;
- grant and enable pulled mid-frame, which shows that a frame runs to completion.

The threshold is raised and held, then dropped and raised again, and also crossed while disabled. This distinguishes an edge trigger from a level trigger and shows that a crossing during the disabled time is discarded.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  localparam int PRE_BYTES   = 8;   // seven 0x55 bytes plus the 0xD5 delimiter
  localparam int BODY_BYTES  = 60;  // minimum frame body without FCS
  localparam int FCS_BYTES   = 4;
  localparam int FRAME_BYTES = PRE_BYTES + BODY_BYTES + FCS_BYTES;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_GAP} sq_state_t;

  // One byte of a reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction

  // Byte at a given offset of the 60-byte body.
  function automatic logic [7:0] body_byte(input logic [5:0] off, input logic [47:0] sa,
                                           input logic [15:0] q);
    case (off)
      6'd0:  return 8'h01;
      6'd1:  return 8'h80;
      6'd2:  return 8'hC2;
      6'd3:  return 8'h00;
      6'd4:  return 8'h00;
      6'd5:  return 8'h01;
      6'd6:  return sa[47:40];
      6'd7:  return sa[39:32];
      6'd8:  return sa[31:24];
      6'd9:  return sa[23:16];
      6'd10: return sa[15:8];
      6'd11: return sa[7:0];
      6'd12: return 8'h88;
      6'd13: return 8'h08;
      6'd14: return 8'h00;
      6'd15: return 8'h01;
      6'd16: return q[15:8];
      6'd17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // Byte on the wire at frame position idx; crc is the running remainder.
  function automatic logic [7:0] wire_byte(input logic [IDX_W-1:0] idx, input logic [47:0] sa,
                                           input logic [15:0] q, input logic [31:0] crc);
    logic [IDX_W-1:0] off;
    logic [31:0]      fcs;
    fcs = ~crc;
    if (idx < IDX_W'(PRE_BYTES - 1)) begin
      return 8'h55;
    end else if (idx == IDX_W'(PRE_BYTES - 1)) begin
      return 8'hD5;
    end else if (idx < IDX_W'(PRE_BYTES + BODY_BYTES)) begin
      off = idx - IDX_W'(PRE_BYTES);
      return body_byte(off[5:0], sa, q);
    end else begin
      off = idx - IDX_W'(PRE_BYTES + BODY_BYTES);
      return fcs[{off[1:0], 3'b000} +: 8];
    end
  endfunction

endpackage

// File: rtl/pfg_crc32.sv
module pfg_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc
);
  import pfg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc <= 32'hFFFF_FFFF;
    else if (en)        crc <= crc32_step(crc, data);
  end

endmodule

// File: rtl/pfg_trigger.sv
module pfg_trigger #(
  parameter int LEVEL_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fc_enable,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic [LEVEL_W-1:0] fifo_threshold,
  input  logic               xoff_reg_req,
  input  logic               xon_reg_req,
  input  logic               xoff_pin_req,
  input  logic               xon_pin_req,
  input  logic               thr_clear,
  output logic               thr_event,
  output logic               want_xoff,
  output logic               want_xon
);
  logic at_thr, armed, thr_pend, xoff_any, xon_any;

  assign at_thr    = fifo_level >= fifo_threshold;
  assign thr_event = fc_enable && armed && at_thr;
  assign xoff_any  = xoff_reg_req || xoff_pin_req;
  assign xon_any   = xon_reg_req  || xon_pin_req;
  assign want_xoff = fc_enable && (xoff_any || thr_pend);
  assign want_xon  = fc_enable && xon_any && !(xoff_any || thr_pend);

  // armed follows the level: a crossing consumes it whether enabled or not
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      thr_pend <= 1'b0;
    end else begin
      armed <= !at_thr;
      if (!fc_enable)     thr_pend <= 1'b0;
      else if (thr_event) thr_pend <= 1'b1;
      else if (thr_clear) thr_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/pfg_sequencer.sv
module pfg_sequencer #(
  parameter int IFG_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        want_xoff,
  input  logic        want_xon,
  input  logic        tx_grant,
  input  logic [47:0] src_mac,
  input  logic [15:0] pause_quanta,
  input  logic [31:0] crc,
  output logic        tx_req,
  output logic        tx_en,
  output logic [7:0]  txd,
  output logic        frame_start,
  output logic        frame_last,
  output logic        body_valid,
  output logic        kind_xoff
);
  import pfg_pkg::*;

  localparam int GAP_W = $clog2(IFG_CYCLES + 1);

  sq_state_t        state;
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] gap_cnt;
  logic [15:0]      q_lat;
  logic [47:0]      sa_lat;

  assign tx_req      = (state == SQ_IDLE) && (want_xoff || want_xon);
  assign frame_start = tx_req && tx_grant;
  assign tx_en       = (state == SQ_SEND);
  assign frame_last  = tx_en && (idx == IDX_W'(FRAME_BYTES - 1));
  assign body_valid  = tx_en && (idx >= IDX_W'(PRE_BYTES)) &&
                       (idx < IDX_W'(PRE_BYTES + BODY_BYTES));
  assign txd         = tx_en ? wire_byte(idx, sa_lat, q_lat, crc) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      gap_cnt   <= '0;
      kind_xoff <= 1'b0;
      q_lat     <= '0;
      sa_lat    <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (frame_start) begin
          state     <= SQ_SEND;
          idx       <= '0;
          kind_xoff <= want_xoff;
          q_lat     <= want_xoff ? pause_quanta : 16'h0000;
          sa_lat    <= src_mac;
        end
        SQ_SEND: if (frame_last) begin
          state   <= SQ_GAP;
          gap_cnt <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
        SQ_GAP: if (gap_cnt == GAP_W'(IFG_CYCLES - 1)) begin
          state <= SQ_IDLE;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter int LEVEL_W    = 10,
  parameter int IFG_CYCLES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fc_enable,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic [LEVEL_W-1:0] fifo_threshold,
  input  logic               xoff_reg_req,
  input  logic               xon_reg_req,
  input  logic               xoff_pin_req,
  input  logic               xon_pin_req,
  input  logic [15:0]        pause_quanta,
  input  logic [47:0]        src_mac,
  input  logic               tx_grant,
  output logic               tx_req,
  output logic               tx_en,
  output logic [7:0]         txd
);
  // internal events, named for the checker
  logic        want_xoff, want_xon, thr_event, thr_clear;
  logic        frame_start, frame_last, body_valid, kind_xoff;
  logic [31:0] crc;

  assign thr_clear = frame_start && want_xoff;

  pfg_trigger #(.LEVEL_W(LEVEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
    .fifo_level(fifo_level), .fifo_threshold(fifo_threshold),
    .xoff_reg_req(xoff_reg_req), .xon_reg_req(xon_reg_req),
    .xoff_pin_req(xoff_pin_req), .xon_pin_req(xon_pin_req),
    .thr_clear(thr_clear), .thr_event(thr_event),
    .want_xoff(want_xoff), .want_xon(want_xon)
  );

  pfg_sequencer #(.IFG_CYCLES(IFG_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .want_xoff(want_xoff), .want_xon(want_xon),
    .tx_grant(tx_grant), .src_mac(src_mac), .pause_quanta(pause_quanta),
    .crc(crc), .tx_req(tx_req), .tx_en(tx_en), .txd(txd),
    .frame_start(frame_start), .frame_last(frame_last),
    .body_valid(body_valid), .kind_xoff(kind_xoff)
  );

  pfg_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .init(frame_start), .en(body_valid),
    .data(txd), .crc(crc)
  );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int IFG_CYCLES = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fc_enable,
  input logic       xoff_reg_req,
  input logic       xoff_pin_req,
  input logic       tx_req,
  input logic       tx_grant,
  input logic       tx_en,
  input logic [7:0] txd,
  input logic       frame_start,
  input logic       frame_last,
  input logic       want_xoff,
  input logic       thr_event,
  input logic       kind_xoff
);
  logic [7:0] idle_cnt;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      seen     <= 1'b0;
    end else if (tx_en) begin
      idle_cnt <= '0;
      seen     <= 1'b1;
    end else if (idle_cnt != 8'hFF) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_enable |-> !tx_req);

  assert_xon_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !want_xoff) |=> !kind_xoff);

  assert_xoff_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (xoff_reg_req || xoff_pin_req)) |=> kind_xoff);

  assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_event |=> !thr_event);

  assert_preamble_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd == 8'h55);

  assert_start_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(tx_req) && $past(tx_grant)));

  assert_no_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !frame_last) |=> tx_en);

  assert_min_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && seen) |-> idle_cnt >= 8'(IFG_CYCLES));

endmodule

bind pause_frame_gen pfg_checker #(.IFG_CYCLES(IFG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
  .xoff_reg_req(xoff_reg_req), .xoff_pin_req(xoff_pin_req),
  .tx_req(tx_req), .tx_grant(tx_grant), .tx_en(tx_en), .txd(txd),
  .frame_start(frame_start), .frame_last(frame_last),
  .want_xoff(want_xoff), .thr_event(thr_event), .kind_xoff(kind_xoff)
);

// File: tb/pause_frame_gen_test.sv
module pause_frame_gen_test;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fc_enable = 1'b0;
  logic [LW-1:0] fifo_level = '0;
  logic [LW-1:0] fifo_threshold = LW'(100);
  logic          xoff_reg_req = 1'b0, xon_reg_req = 1'b0;
  logic          xoff_pin_req = 1'b0, xon_pin_req = 1'b0;
  logic [15:0]   pause_quanta = 16'h0;
  logic [47:0]   src_mac = 48'h0;
  logic          tx_grant = 1'b0;
  logic          tx_req, tx_en;
  logic [7:0]    txd;

  always #10 clk = ~clk;

  pause_frame_gen #(.LEVEL_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
    .fifo_level(fifo_level), .fifo_threshold(fifo_threshold),
    .xoff_reg_req(xoff_reg_req), .xon_reg_req(xon_reg_req),
    .xoff_pin_req(xoff_pin_req), .xon_pin_req(xon_pin_req),
    .pause_quanta(pause_quanta), .src_mac(src_mac),
    .tx_grant(tx_grant), .tx_req(tx_req), .tx_en(tx_en), .txd(txd)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] got [0:79];
  logic [7:0] exp_b [0:71];
  int got_len, wait_cyc;

  typedef struct packed {
    logic rxoff, rxon, pxoff, pxon, en, frame, kxoff;
    logic [15:0] q;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1234},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h00FF},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h5555},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h8001},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hABCD},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0001},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1111},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2222},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h3333}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Expected frame, built from the requirement text: header as one vector,
  // CRC shifted one bit at a time.
  task automatic build_exp(input bit xoff, input logic [15:0] q, input logic [47:0] sa);
    logic [143:0] hdr;
    logic [31:0]  c;
    logic         fb;
    hdr = {48'h0180C2000001, sa, 16'h8808, 16'h0001, (xoff ? q : 16'h0000)};
    for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
    exp_b[7] = 8'hD5;
    for (int k = 0; k < 60; k++) exp_b[8+k] = (k < 18) ? hdr[143-8*k -: 8] : 8'h00;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 60; k++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ exp_b[8+k][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    c = ~c;
    for (int k = 0; k < 4; k++) exp_b[68+k] = c[8*k +: 8];
  endtask

  // Waits up to timeout cycles for tx_en, then records bytes until tx_en drops.
  task automatic capture(input int timeout);
    int n;
    n = 0;
    got_len = 0;
    while (!tx_en && n < timeout) begin
      @(negedge clk);
      n++;
    end
    wait_cyc = n;
    while (tx_en) begin
      if (got_len < 80) got[got_len] = txd;
      got_len++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input string tag);
    int bad;
    bad = -1;
    check(got_len == 72, {tag, " length"}, 64'(got_len), 64'd72);
    for (int i = 0; i < 72; i++) if (bad < 0 && got[i] !== exp_b[i]) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s byte %0d", tag, bad), 64'(got[bad]), 64'(exp_b[bad]));
  endtask

  task automatic clear_reqs();
    xoff_reg_req = 1'b0; xon_reg_req = 1'b0;
    xoff_pin_req = 1'b0; xon_pin_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int cnt;
    // R12 reset state
    repeat (3) @(negedge clk);
    check(tx_en == 1'b0 && tx_req == 1'b0 && txd == 8'h00, "R12 in reset",
          {tx_en, tx_req, txd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_en == 1'b0 && tx_req == 1'b0 && txd == 8'h00, "R12 after reset",
          {tx_en, tx_req, txd}, 0);

    // table of request patterns
    tx_grant = 1'b1;
    for (int i = 0; i < 10; i++) begin
      src_mac      = 48'h02AABBCC0000 + 48'(i);
      pause_quanta = VECS[i].q;
      fc_enable    = VECS[i].en;
      xoff_reg_req = VECS[i].rxoff;
      xon_reg_req  = VECS[i].rxon;
      xoff_pin_req = VECS[i].pxoff;
      xon_pin_req  = VECS[i].pxon;
      capture(20);
      clear_reqs();
      if (VECS[i].frame) begin
        build_exp(VECS[i].kxoff, VECS[i].q, src_mac);
        check_frame(VECS[i].kxoff ? $sformatf("vec%0d R2 R3 R5 R7 R8", i)
                                  : $sformatf("vec%0d R2 R4 R7 R8", i));
      end else begin
        check(got_len == 0 && tx_req == 1'b0, $sformatf("vec%0d R1 no frame", i),
              64'(got_len), 0);
      end
      repeat (20) @(negedge clk);
    end

    // R9: frame waits for grant; first byte one cycle after the granting edge
    fc_enable = 1'b1; tx_grant = 1'b0;
    src_mac = 48'h0A0B0C0D0E0F; pause_quanta = 16'h0F0F;
    xoff_reg_req = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_req == 1'b1, "R9 request raised", 64'(tx_req), 1);
    repeat (10) @(negedge clk);
    check(tx_en == 1'b0, "R9 no start without grant", 64'(tx_en), 0);
    tx_grant = 1'b1;
    @(negedge clk);
    check(tx_en == 1'b1 && txd == 8'h55, "R9 start latency", {tx_en, txd}, 64'h155);
    capture(1);
    build_exp(1'b1, 16'h0F0F, 48'h0A0B0C0D0E0F);
    check_frame("R3 R7 R8 first held frame");
    // R3 R11: held request repeats with exact gap
    capture(40);
    check(wait_cyc == 13, "R11 gap between held frames", 64'(wait_cyc), 13);
    check_frame("R3 repeated XOFF frame");
    clear_reqs();
    capture(40);
    check(got_len == 0, "R3 stops after clear", 64'(got_len), 0);

    // R4 repeated XON
    xon_pin_req = 1'b1;
    capture(20);
    capture(40);
    clear_reqs();
    build_exp(1'b0, 16'h0, 48'h0A0B0C0D0E0F);
    check_frame("R4 repeated XON frame");
    repeat (20) @(negedge clk);

    // R6 threshold edge trigger
    src_mac = 48'h001122334455; pause_quanta = 16'h4242;
    fifo_level = LW'(50);
    repeat (3) @(negedge clk);
    fifo_level = LW'(100);
    capture(20);
    build_exp(1'b1, 16'h4242, 48'h001122334455);
    check_frame("R6 threshold XOFF");
    capture(150);
    check(got_len == 0, "R6 single frame while level held", 64'(got_len), 0);
    fifo_level = LW'(99);
    repeat (3) @(negedge clk);
    fifo_level = LW'(120);
    capture(20);
    check_frame("R6 re-armed crossing");
    fifo_level = LW'(0);
    repeat (20) @(negedge clk);

    // R1 crossing while disabled is discarded
    fc_enable = 1'b0;
    repeat (3) @(negedge clk);
    fifo_level = LW'(200);
    repeat (5) @(negedge clk);
    fc_enable = 1'b1;
    capture(40);
    check(got_len == 0, "R1 disabled crossing discarded", 64'(got_len), 0);
    fifo_level = LW'(0);
    repeat (5) @(negedge clk);

    // R10 frame survives grant, enable and request removal
    xon_reg_req = 1'b1;
    cnt = 0;
    while (!tx_en && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    cnt = 0;
    while (tx_en && cnt < 100) begin
      if (cnt == 10) begin
        tx_grant = 1'b0; fc_enable = 1'b0; clear_reqs();
      end
      cnt++;
      @(negedge clk);
    end
    check(cnt == 72, "R10 uninterrupted length", 64'(cnt), 72);
    capture(30);
    check(got_len == 0 && tx_req == 1'b0, "R1 R10 quiet afterwards", 64'(got_len), 0);

    report();
  end

endmodule